// File: doc/BRIEF.md
# Push-Button Demonstration Control Sequencer

This block runs an error-correction demonstration from four debounced push-buttons: reset, rate up, rate down and screen cycle. It holds the current display screen, which is one of a title screen, a rate-setup screen and two running statistics screens. It forwards rate changes to the error injector only while the setup screen is shown. It raises a run-enable flag once the demonstration is started.

Two status LEDs use timed holds. One shows an operator error, which is any press that happens while another button is already down or that comes together with another press. The other shows decoder failure and stays lit for a hold time after the last failure pulse. A periodic strobe tells the display driver when to redraw. All hold and refresh periods are cycle-count parameters derived from the clock frequency. The defaults give one second at 33 MHz.

Top module: `demo_ctrl_seq`

## Requirements
- R1: While rst_ni is low and after its release, screen_o is 0 (title), and run_en_o, rate_up_o, rate_down_o, err_led_o, fail_led_o and refresh_o are all 0.
- R2: A valid reset-button press, taken from any screen, returns screen_o to 0 (title) and clears run_en_o in the cycle after the edge.
- R3: A valid cycle press on the title screen (0) moves screen_o to the setup screen (1).
- R4: A valid cycle press on the setup screen (1) moves screen_o to the corrected-count screen (2) and sets run_en_o.
- R5: Further valid cycle presses rotate 2 to 3 (detected-count screen) and 3 to 1. A cycle press never returns to screen 0.
- R6: A valid up or down press on screen 1 gives a one-cycle pulse on rate_up_o or rate_down_o in the cycle after the edge. The same press on any other screen gives no pulse.
- R7: A button acts only on its rising edge, so a held button acts once.
- R8: In a cycle where any button rises while two or more buttons are high, nothing happens to the screen, the run flag or the rate pulses. err_led_o is then high for exactly HOLD_CYCLES cycles, and a new conflict restarts the hold.
- R9: fail_led_o is high in the cycle after each cycle in which dec_fail_i is high. It stays high until HOLD_CYCLES cycles have passed with no failure.
- R10: refresh_o is a one-cycle strobe. It occurs every REFRESH_CYCLES cycles, counted from the release of reset.
- R11: Once set, run_en_o stays high through all cycle presses until a valid reset press.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| btn_reset_i | input | 1 | Debounced reset button level |
| btn_up_i | input | 1 | Debounced rate-up button level |
| btn_down_i | input | 1 | Debounced rate-down button level |
| btn_cycle_i | input | 1 | Debounced screen-cycle button level |
| dec_fail_i | input | 1 | Decoder failure pulse |
| screen_o | output | 2 | Screen code: 0 title, 1 setup, 2 corrected, 3 detected |
| run_en_o | output | 1 | Demonstration running |
| rate_up_o | output | 1 | One-cycle rate increase request |
| rate_down_o | output | 1 | One-cycle rate decrease request |
| err_led_o | output | 1 | Operator-error LED |
| fail_led_o | output | 1 | Decoder-failure LED |
| refresh_o | output | 1 | Display refresh strobe |

## Verification
On every cycle the assertions check four things. Rate pulses appear only on the setup screen, never together and never in back-to-back cycles. Run-enable rises only as the corrected-count screen is entered, and each entry to the setup screen comes from the title or detected-count screen. A failure pulse is always followed by a lit failure LED, and the refresh strobe is never wider than one cycle. The bench scenarios show the exact LED hold lengths, the refresh period, the conflict rule for staggered and simultaneous presses, and that a held button acts only once.

// File: rtl/demo_ctrl_pkg.sv
package demo_ctrl_pkg;
  typedef enum logic [1:0] {
    SCR_TITLE = 2'd0,
    SCR_SETUP = 2'd1,
    SCR_CORR  = 2'd2,
    SCR_DET   = 2'd3
  } screen_e;

  localparam int NUM_BTN = 4;
  localparam int BTN_RST = 0;
  localparam int BTN_UP  = 1;
  localparam int BTN_DN  = 2;
  localparam int BTN_CYC = 3;
endpackage

// File: rtl/btn_front.sv
module btn_front #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] press_o,
  output logic         conflict_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  assign rise       = lvl_i & ~prev_q;
  // any new press while another button is down counts as operator error
  assign conflict_o = (|rise) && ($countones(lvl_i) >= 2);
  assign press_o    = conflict_o ? '0 : rise;
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int CYCLES = 33_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic on_o
);
  localparam int W = $clog2(CYCLES + 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (trig_i)       cnt_q <= W'(CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign on_o = (cnt_q != '0);
endmodule

// File: rtl/pulse_gen.sv
module pulse_gen #(
  parameter int PERIOD = 33_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic strobe_o
);
  localparam int W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      strobe_o <= 1'b0;
    end else begin
      strobe_o <= (cnt_q == LAST);
      cnt_q    <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/screen_fsm.sv
module screen_fsm
  import demo_ctrl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_BTN-1:0] press_i,
  output screen_e            screen_o,
  output logic               run_en_o,
  output logic               rate_up_o,
  output logic               rate_down_o
);
  screen_e scr_d;
  logic    run_d;

  always_comb begin
    scr_d = screen_o;
    run_d = run_en_o;
    if (press_i[BTN_RST]) begin
      scr_d = SCR_TITLE;
      run_d = 1'b0;
    end else if (press_i[BTN_CYC]) begin
      unique case (screen_o)
        SCR_TITLE: scr_d = SCR_SETUP;
        SCR_SETUP: begin
          scr_d = SCR_CORR;
          run_d = 1'b1;
        end
        SCR_CORR:  scr_d = SCR_DET;
        SCR_DET:   scr_d = SCR_SETUP;
        default:   scr_d = SCR_TITLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      screen_o    <= SCR_TITLE;
      run_en_o    <= 1'b0;
      rate_up_o   <= 1'b0;
      rate_down_o <= 1'b0;
    end else begin
      screen_o    <= scr_d;
      run_en_o    <= run_d;
      rate_up_o   <= press_i[BTN_UP] && (screen_o == SCR_SETUP);
      rate_down_o <= press_i[BTN_DN] && (screen_o == SCR_SETUP);
    end
  end
endmodule

// File: rtl/demo_ctrl_seq.sv
module demo_ctrl_seq
  import demo_ctrl_pkg::*;
#(
  parameter int CLK_HZ         = 33_000_000,
  parameter int HOLD_CYCLES    = CLK_HZ,
  parameter int REFRESH_CYCLES = CLK_HZ
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       btn_reset_i,
  input  logic       btn_up_i,
  input  logic       btn_down_i,
  input  logic       btn_cycle_i,
  input  logic       dec_fail_i,
  output logic [1:0] screen_o,
  output logic       run_en_o,
  output logic       rate_up_o,
  output logic       rate_down_o,
  output logic       err_led_o,
  output logic       fail_led_o,
  output logic       refresh_o
);
  logic [NUM_BTN-1:0] lvl;
  logic [NUM_BTN-1:0] press;
  logic               conflict;
  screen_e            scr;

  always_comb begin
    lvl          = '0;
    lvl[BTN_RST] = btn_reset_i;
    lvl[BTN_UP]  = btn_up_i;
    lvl[BTN_DN]  = btn_down_i;
    lvl[BTN_CYC] = btn_cycle_i;
  end

  btn_front #(.N(NUM_BTN)) u_front (
    .clk_i, .rst_ni, .lvl_i(lvl), .press_o(press), .conflict_o(conflict)
  );

  screen_fsm u_fsm (
    .clk_i, .rst_ni, .press_i(press), .screen_o(scr),
    .run_en_o, .rate_up_o, .rate_down_o
  );
  assign screen_o = scr;

  hold_timer #(.CYCLES(HOLD_CYCLES)) u_err_hold (
    .clk_i, .rst_ni, .trig_i(conflict), .on_o(err_led_o)
  );

  hold_timer #(.CYCLES(HOLD_CYCLES)) u_fail_hold (
    .clk_i, .rst_ni, .trig_i(dec_fail_i), .on_o(fail_led_o)
  );

  pulse_gen #(.PERIOD(REFRESH_CYCLES)) u_refresh (
    .clk_i, .rst_ni, .strobe_o(refresh_o)
  );
endmodule

// File: rtl/demo_ctrl_seq_chk.sv
module demo_ctrl_seq_chk
  import demo_ctrl_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       dec_fail_i,
  input logic [1:0] screen_o,
  input logic       run_en_o,
  input logic       rate_up_o,
  input logic       rate_down_o,
  input logic       fail_led_o,
  input logic       refresh_o
);
  // R6
  rate_up_on_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_up_o |-> screen_o == SCR_SETUP);
  // R6
  rate_down_on_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_down_o |-> screen_o == SCR_SETUP);
  // R6
  rate_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rate_up_o && rate_down_o));
  // R7
  rate_up_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_up_o |=> !rate_up_o);
  // R4
  run_start_screen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_en_o) |-> screen_o == SCR_CORR);
  // R5
  setup_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (screen_o == SCR_SETUP && !$stable(screen_o)) |->
      ($past(screen_o) == SCR_TITLE || $past(screen_o) == SCR_DET));
  // R9
  fail_led_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_fail_i |=> fail_led_o);
  // R10
  refresh_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_o |=> !refresh_o);
endmodule

bind demo_ctrl_seq demo_ctrl_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dec_fail_i(dec_fail_i),
  .screen_o(screen_o), .run_en_o(run_en_o), .rate_up_o(rate_up_o),
  .rate_down_o(rate_down_o), .fail_led_o(fail_led_o), .refresh_o(refresh_o)
);

// File: tb/demo_ctrl_seq_test.sv
`timescale 1ns/1ps
module demo_ctrl_seq_test;
  localparam int HOLD = 13;
  localparam int REFR = 37;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic b_rst = 0, b_up = 0, b_dn = 0, b_cyc = 0, fail_in = 0;
  logic [1:0] screen;
  logic run_en, r_up, r_dn, err_led, fail_led, refresh;

  int n_chk = 0, n_bad = 0;
  bit checking = 0;

  always #4 clk = ~clk;

  demo_ctrl_seq #(.CLK_HZ(100), .HOLD_CYCLES(HOLD), .REFRESH_CYCLES(REFR)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .btn_reset_i(b_rst), .btn_up_i(b_up),
    .btn_down_i(b_dn), .btn_cycle_i(b_cyc), .dec_fail_i(fail_in),
    .screen_o(screen), .run_en_o(run_en), .rate_up_o(r_up), .rate_down_o(r_dn),
    .err_led_o(err_led), .fail_led_o(fail_led), .refresh_o(refresh)
  );

  // expected-value model from the requirements
  logic [1:0] e_scr;
  logic       e_run, e_up, e_dn;
  logic [3:0] pv;
  int         ecnt, fcnt, ncyc;

  function automatic logic [1:0] next_screen(logic [1:0] s);
    case (s)
      2'd0: return 2'd1;
      2'd1: return 2'd2;
      2'd2: return 2'd3;
      default: return 2'd1;
    endcase
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      e_scr <= 0; e_run <= 0; e_up <= 0; e_dn <= 0;
      pv <= 0; ecnt <= 0; fcnt <= 0; ncyc <= 0;
    end else begin
      logic [3:0] lv, rs;
      bit conflict;
      lv = {b_cyc, b_dn, b_up, b_rst};
      rs = lv & ~pv;
      conflict = (rs != 0) && ($countones(lv) >= 2);
      pv <= lv;
      ncyc <= ncyc + 1;
      e_up <= 0; e_dn <= 0;
      if (conflict) ecnt <= HOLD; else if (ecnt > 0) ecnt <= ecnt - 1;
      if (fail_in) fcnt <= HOLD; else if (fcnt > 0) fcnt <= fcnt - 1;
      if (!conflict) begin
        if (rs[0]) begin e_scr <= 0; e_run <= 0; end
        else if (rs[3]) begin
          e_scr <= next_screen(e_scr);
          if (e_scr == 2'd1) e_run <= 1;
        end
        e_up <= rs[1] && e_scr == 2'd1;
        e_dn <= rs[2] && e_scr == 2'd1;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      chk("R3/R5 screen", screen, e_scr);
      chk("R4/R11 run_en", run_en, e_run);
      chk("R6 rate_up", r_up, e_up);
      chk("R6 rate_down", r_dn, e_dn);
      chk("R8 err_led", err_led, ecnt != 0);
      chk("R9 fail_led", fail_led, fcnt != 0);
      chk("R10 refresh", refresh, (ncyc % REFR) == 0 && ncyc > 0);
    end
  end

  task automatic hit(int idx, int hold_cyc);
    @(negedge clk);
    case (idx) 0: b_rst = 1; 1: b_up = 1; 2: b_dn = 1; default: b_cyc = 1; endcase
    repeat (hold_cyc) @(negedge clk);
    b_rst = 0; b_up = 0; b_dn = 0; b_cyc = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 screen", screen, 0);
    chk("R1 outputs", {run_en, r_up, r_dn, err_led, fail_led, refresh}, 0);
    rst_ni = 1;
    checking = 1;
    @(negedge clk);
    chk("R1 after release", {screen, run_en, err_led, fail_led}, 0);
    hit(1, 1);            // R6: up on title ignored
    hit(3, 1);            // R3
    hit(1, 1); hit(2, 1); // R6 on setup
    hit(3, 5);            // R4, R7 held press acts once
    hit(1, 1);            // R6 ignored on screen 2
    hit(3, 1); hit(3, 1); hit(3, 1); // R5 rotate, R11
    // R8: simultaneous press
    @(negedge clk); b_up = 1; b_cyc = 1;
    @(negedge clk); b_up = 0; b_cyc = 0;
    // R8: staggered press while another held
    @(negedge clk); b_dn = 1;
    @(negedge clk); b_rst = 1;
    @(negedge clk); b_rst = 0; b_dn = 0;
    repeat (HOLD + 3) @(negedge clk);
    // R9: failure pulse hold
    fail_in = 1; @(negedge clk); fail_in = 0;
    repeat (HOLD + 3) @(negedge clk);
    hit(0, 1);            // R2
    chk("R2 title", screen, 0);
    chk("R2 run cleared", run_en, 0);
    // constrained random phase
    void'($urandom(32'h5eed));
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      b_rst = b_rst ? ($urandom_range(2) != 0) : ($urandom_range(150) == 0);
      b_up  = b_up  ? ($urandom_range(2) != 0) : ($urandom_range(15) == 0);
      b_dn  = b_dn  ? ($urandom_range(2) != 0) : ($urandom_range(15) == 0);
      b_cyc = b_cyc ? ($urandom_range(2) != 0) : ($urandom_range(12) == 0);
      fail_in = ($urandom_range(60) == 0);
    end
    @(negedge clk);
    b_rst = 0; b_up = 0; b_dn = 0; b_cyc = 0; fail_in = 0;
    repeat (HOLD + 2) @(negedge clk);
    checking = 0;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule